// File: doc/BRIEF.md
# Priority Operand Forwarding Unit

This block is the bypass and interlock decision logic of a five-stage in-order pipeline. Two source operands are consumed in EX. For each of them the block picks one of three values. The first is the value read from the register file. The second is the result held in the EX/MEM pipeline register. The third is the result held in the MEM/WB pipeline register. When both downstream stages define the wanted register, the nearer (younger) one is chosen.

Some dependences cannot be covered by a bypass. A load delivers its data only at the end of MEM, so a consumer directly behind a load must wait one cycle. A jump-register reads its target operand in ID, so any writer still in EX is too late for it, and so is a load still in MEM. In both cases the block raises a single stall flag. When the jump-register can be served, it gets its own operand select. The block is purely combinational. It holds no state and sits between the pipeline registers and the operand multiplexers.

Top module: `priority_fwd_unit`

## Requirements
- R1: An EX operand select is 2'b10 (EX/MEM result) when the MEM-stage producer is valid, has its write enable set, and its destination equals the operand's non-zero source field.
- R2: If R1 does not apply, the select is 2'b01 (MEM/WB result) when the WB-stage producer is valid, write-enabled and its destination equals the non-zero source field. Otherwise it is 2'b00 (register file). The code 2'b11 never appears.
- R3: When both the MEM and the WB producer match the same source, the select is 2'b10: the youngest definition wins.
- R4: A source field of register 0 always gives select 2'b00 and never causes a stall.
- R5: A producer whose valid bit or write enable is low neither forwards nor stalls. With all inputs at zero, every output is zero.
- R6: Consumer class codes are 0 none, 1 ALU register-register, 2 ALU register-immediate, 3 load, 4 store, 5 branch and 6 jump-register. Classes 1, 4 and 5 read both sources. Classes 2, 3 and 6 read only source A. Class 0 reads neither. An unread source never causes a stall.
- R7: The stall flag is 1 when an ID consumer reads a register that a valid, write-enabled load in EX will write (load-use).
- R8: A non-load writer in EX never stalls a consumer of class 1 to 5.
- R9: A jump-register in ID stalls when any valid writer in EX targets its source, or when a valid load in MEM targets it.
- R10: A jump-register whose source matches a non-load MEM producer gets jump select 2'b10 without a stall. Otherwise, a WB match gives 2'b01. The jump select is 2'b00 for every class other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Source A of the instruction in EX |
| ex_src_b | input | 5 | Source B of the instruction in EX |
| id_src_a | input | 5 | Source A of the instruction in ID |
| id_src_b | input | 5 | Source B of the instruction in ID |
| id_class | input | 3 | Class code of the instruction in ID (see R6) |
| ex_dst | input | 5 | Destination of the instruction in EX |
| ex_wen | input | 1 | Register write enable of the EX instruction |
| ex_vld | input | 1 | EX instruction is valid |
| ex_is_load | input | 1 | EX instruction is a load |
| mem_dst | input | 5 | Destination held in EX/MEM |
| mem_wen | input | 1 | Register write enable held in EX/MEM |
| mem_vld | input | 1 | EX/MEM entry is valid |
| mem_is_load | input | 1 | EX/MEM entry is a load |
| wb_dst | input | 5 | Destination held in MEM/WB |
| wb_wen | input | 1 | Register write enable held in MEM/WB |
| wb_vld | input | 1 | MEM/WB entry is valid |
| sel_a | output | 2 | Operand A select: 00 file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Operand B select, same encoding |
| jr_sel | output | 2 | Jump-register operand select in ID, same encoding |
| stall | output | 1 | Hold ID and insert a bubble |

## Verification
The bench drives back-to-back writers of one register into MEM and WB together. A priority inverted toward the older stage would deliver the stale value (01 instead of 10). Load-use pairs are sent on source A, on source B and on an unread source B. Missing the interlock would let a consumer read data not yet loaded. Stalling on an unused field would waste cycles. Register 0 is aimed at by every stage, which catches a design that forwards a write to the zero register. Jump-register cases sweep an ALU writer and a load through EX, MEM and WB. They show whether the ID-stage consumer is wrongly bypassed from a result that does not exist yet, or stalled when the result is ready.

// File: rtl/fwd_pkg.sv
// Shared types of the forwarding unit.
// Assumes register numbers fit in the width chosen by the top parameter.
package fwd_pkg;
    typedef enum logic [2:0] {
        CL_NONE   = 3'd0,
        CL_ALU_RR = 3'd1,
        CL_ALU_RI = 3'd2,
        CL_LOAD   = 3'd3,
        CL_STORE  = 3'd4,
        CL_BRANCH = 3'd5,
        CL_JR     = 3'd6
    } op_class_e;

    localparam logic [1:0] SEL_RF   = 2'b00;
    localparam logic [1:0] SEL_MEM  = 2'b10;
    localparam logic [1:0] SEL_WB   = 2'b01;

    // Does this consumer class read source A?
    function automatic logic reads_a(op_class_e c);
        return (c != CL_NONE) && (c <= CL_JR);
    endfunction

    // Does this consumer class read source B?
    function automatic logic reads_b(op_class_e c);
        return (c == CL_ALU_RR) || (c == CL_STORE) || (c == CL_BRANCH);
    endfunction
endpackage

// File: rtl/fwd_match.sv
// Compares one consumer source field against one in-flight producer.
// Assumes register 0 is hard-wired zero, so it never matches.
module fwd_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    input  logic          vld,
    output logic          hit
);
    // Hit when a live writer targets the same non-zero register.
    always_comb begin
        hit = vld && wen && (dst == src) && (src != '0);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Chooses the source of one operand among the file, EX/MEM and MEM/WB.
// EX/MEM is tested first, so the youngest definition wins.
// JR_MODE=1 refuses an EX/MEM load, whose data is not ready yet.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW      = 5,
    parameter bit JR_MODE = 1'b0
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic          mem_vld,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wen,
    input  logic          wb_vld,
    output logic [1:0]    sel
);
    logic mem_hit;
    logic wb_hit;
    logic mem_ok;

    fwd_match #(.AW(AW)) u_mem (.src(src), .dst(mem_dst), .wen(mem_wen),
                                .vld(mem_vld), .hit(mem_hit));
    fwd_match #(.AW(AW)) u_wb  (.src(src), .dst(wb_dst), .wen(wb_wen),
                                .vld(wb_vld), .hit(wb_hit));

    generate
        if (JR_MODE) begin : g_jr
            // A load still in MEM cannot feed an ID-stage reader.
            always_comb mem_ok = mem_hit && !mem_is_load;
        end else begin : g_ex
            // Load-use interlock keeps EX/MEM loads off this path.
            logic unused_load;
            always_comb begin
                unused_load = mem_is_load;
                mem_ok      = mem_hit;
            end
        end
    endgenerate

    // Priority pick: nearer stage first, then older stage, then file.
    always_comb begin
        if (mem_ok)      sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    // Guard the encoding and the zero-register rule.
    always_comb begin
        assert_sel_code_R2: assert (sel != 2'b11);
        assert_zero_src_R4: assert (!(src == '0) || (sel == SEL_RF));
    end
endmodule

// File: rtl/fwd_hazard.sv
// Detects dependences that a bypass cannot cover and asks for a stall.
// Covers load-use toward any EX consumer, and writers in EX or loads
// in MEM feeding a jump-register in ID.
module fwd_hazard
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  op_class_e     id_class,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wen,
    input  logic          ex_vld,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic          mem_vld,
    input  logic          mem_is_load,
    output logic          stall_lu,
    output logic          stall_jr
);
    logic ex_hit_a, ex_hit_b, mem_hit_a;
    logic use_a, use_b, is_jr;

    fwd_match #(.AW(AW)) u_ex_a  (.src(id_src_a), .dst(ex_dst), .wen(ex_wen),
                                  .vld(ex_vld), .hit(ex_hit_a));
    fwd_match #(.AW(AW)) u_ex_b  (.src(id_src_b), .dst(ex_dst), .wen(ex_wen),
                                  .vld(ex_vld), .hit(ex_hit_b));
    fwd_match #(.AW(AW)) u_mem_a (.src(id_src_a), .dst(mem_dst), .wen(mem_wen),
                                  .vld(mem_vld), .hit(mem_hit_a));

    // Decode which operands the ID instruction reads, and where.
    always_comb begin
        use_a = reads_a(id_class);
        use_b = reads_b(id_class);
        is_jr = (id_class == CL_JR);
    end

    // Load-use: the load data is only ready after MEM.
    always_comb begin
        stall_lu = ex_is_load && ((use_a && ex_hit_a) || (use_b && ex_hit_b));
    end

    // Jump-register reads in ID: any EX writer or MEM load is too late.
    always_comb begin
        stall_jr = is_jr && (ex_hit_a || (mem_hit_a && mem_is_load));
    end

    // An idle EX stage never blocks a non-jump consumer.
    always_comb begin
        assert_idle_ex_R5: assert (ex_vld || !stall_lu);
        assert_alu_no_stall_R8: assert (ex_is_load || !stall_lu);
    end
endmodule

// File: rtl/priority_fwd_unit.sv
// Top of the operand forwarding unit for a five-stage in-order pipeline.
// Produces two EX operand selects, one ID jump-register select and a
// stall flag. Purely combinational; assumes the pipeline holds ID and
// injects a bubble into EX while stall is high.
module priority_fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [2:0]    id_class,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wen,
    input  logic          ex_vld,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic          mem_vld,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wen,
    input  logic          wb_vld,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [1:0]    jr_sel,
    output logic          stall
);
    localparam int NSRC = 2;

    op_class_e          cls;
    logic [AW-1:0]      ex_src [NSRC];
    logic [1:0]         ex_sel [NSRC];
    logic [1:0]         jr_raw;
    logic               stall_lu, stall_jr;

    // Gather the EX sources and type the class code.
    always_comb begin
        cls       = op_class_e'(id_class);
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_op
            fwd_operand_sel #(.AW(AW), .JR_MODE(1'b0)) u_sel (
                .src(ex_src[i]), .mem_dst(mem_dst), .mem_wen(mem_wen),
                .mem_vld(mem_vld), .mem_is_load(mem_is_load),
                .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_vld(wb_vld),
                .sel(ex_sel[i]));
        end
    endgenerate

    fwd_operand_sel #(.AW(AW), .JR_MODE(1'b1)) u_jr_sel (
        .src(id_src_a), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .mem_vld(mem_vld), .mem_is_load(mem_is_load),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_vld(wb_vld),
        .sel(jr_raw));

    fwd_hazard #(.AW(AW)) u_haz (
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_class(cls),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_vld(ex_vld),
        .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .mem_vld(mem_vld), .mem_is_load(mem_is_load),
        .stall_lu(stall_lu), .stall_jr(stall_jr));

    // Drive the outputs; the jump select is live only for jump-register.
    always_comb begin
        sel_a  = ex_sel[0];
        sel_b  = ex_sel[1];
        jr_sel = (cls == CL_JR) ? jr_raw : SEL_RF;
        stall  = stall_lu || stall_jr;
    end

    // Cross-check the selector and the hazard detector.
    always_comb begin
        assert_jr_load_R9: assert (!((cls == CL_JR) && mem_vld && mem_wen &&
            mem_is_load && (mem_dst == id_src_a) && (id_src_a != '0)) || stall);
        assert_jr_idle_R10: assert ((cls == CL_JR) || (jr_sel == SEL_RF));
    end
endmodule

// File: tb/tb_priority_fwd_unit.sv
module tb_priority_fwd_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b;
    logic [2:0]    id_class;
    logic [AW-1:0] ex_dst, mem_dst, wb_dst;
    logic          ex_wen, ex_vld, ex_is_load;
    logic          mem_wen, mem_vld, mem_is_load;
    logic          wb_wen, wb_vld;
    logic [1:0]    sel_a, sel_b, jr_sel;
    logic          stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    priority_fwd_unit #(.AW(AW)) dut (.*);

    // Behavioural model: a writer record per stage, youngest first.
    function automatic bit writes(int d, bit w, bit v, int s);
        return v && w && (d == s) && (s != 0);
    endfunction

    function automatic logic [1:0] model_ex(int s);
        if (writes(mem_dst, mem_wen, mem_vld, s)) return 2'b10;
        if (writes(wb_dst, wb_wen, wb_vld, s))    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] model_jr();
        if (id_class != 6) return 2'b00;
        if (writes(mem_dst, mem_wen, mem_vld, id_src_a) && !mem_is_load) return 2'b10;
        if (writes(wb_dst, wb_wen, wb_vld, id_src_a)) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit model_stall();
        bit ua = (id_class >= 1) && (id_class <= 6);
        bit ub = (id_class == 1) || (id_class == 4) || (id_class == 5);
        bit lu = ex_is_load && ((ua && writes(ex_dst, ex_wen, ex_vld, id_src_a)) ||
                                (ub && writes(ex_dst, ex_wen, ex_vld, id_src_b)));
        bit jr = (id_class == 6) && (writes(ex_dst, ex_wen, ex_vld, id_src_a) ||
                 (mem_is_load && writes(mem_dst, mem_wen, mem_vld, id_src_a)));
        return lu || jr;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Sample mid-cycle, after the inputs set at the rising edge settled.
    task automatic check(string tag);
        @(negedge clk);
        cmp(tag, "sel_a",  sel_a,  model_ex(ex_src_a));
        cmp(tag, "sel_b",  sel_b,  model_ex(ex_src_b));
        cmp(tag, "jr_sel", jr_sel, model_jr());
        cmp(tag, "stall",  stall,  model_stall());
    endtask

    task automatic clear();
        @(posedge clk);
        #1;
        {ex_src_a, ex_src_b, id_src_a, id_src_b, id_class} = '0;
        {ex_dst, ex_wen, ex_vld, ex_is_load} = '0;
        {mem_dst, mem_wen, mem_vld, mem_is_load} = '0;
        {wb_dst, wb_wen, wb_vld} = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        clear();
        check("R5");
        cmp("R5", "idle stall", stall, 0);
        // R1: MEM writer feeds operand A
        clear(); ex_src_a = 3; mem_dst = 3; mem_wen = 1; mem_vld = 1; check("R1");
        cmp("R1", "sel_a direct", sel_a, 2);
        // R2: WB writer feeds operand B
        clear(); ex_src_b = 4; wb_dst = 4; wb_wen = 1; wb_vld = 1; check("R2");
        cmp("R2", "sel_b direct", sel_b, 1);
        // R3: back-to-back writers of one register, youngest wins
        clear(); ex_src_a = 7; ex_src_b = 7; mem_dst = 7; mem_wen = 1; mem_vld = 1;
        wb_dst = 7; wb_wen = 1; wb_vld = 1; check("R3");
        cmp("R3", "sel_a youngest", sel_a, 2);
        // R4: zero register targeted by every stage
        clear(); id_class = 6; mem_dst = 0; mem_wen = 1; mem_vld = 1; wb_wen = 1;
        wb_vld = 1; ex_wen = 1; ex_vld = 1; ex_is_load = 1; check("R4");
        cmp("R4", "zero stall", stall, 0);
        // R5: valid low or write enable low
        clear(); ex_src_a = 5; mem_dst = 5; mem_wen = 1; mem_vld = 0;
        wb_dst = 5; wb_wen = 0; wb_vld = 1; check("R5");
        cmp("R5", "no fwd", sel_a, 0);
        // R7: load-use on source B of a store
        clear(); id_class = 4; id_src_b = 9; ex_dst = 9; ex_wen = 1; ex_vld = 1;
        ex_is_load = 1; check("R7");
        cmp("R7", "load-use", stall, 1);
        // R6: unread source B of an immediate ALU op
        clear(); id_class = 2; id_src_b = 9; ex_dst = 9; ex_wen = 1; ex_vld = 1;
        ex_is_load = 1; check("R6");
        cmp("R6", "unused src", stall, 0);
        // R8: ALU writer in EX does not stall a branch
        clear(); id_class = 5; id_src_a = 2; ex_dst = 2; ex_wen = 1; ex_vld = 1; check("R8");
        cmp("R8", "alu no stall", stall, 0);
        // R9: jump-register behind an ALU writer in EX, then a load in MEM
        clear(); id_class = 6; id_src_a = 8; ex_dst = 8; ex_wen = 1; ex_vld = 1; check("R9");
        cmp("R9", "jr ex", stall, 1);
        clear(); id_class = 6; id_src_a = 8; mem_dst = 8; mem_wen = 1; mem_vld = 1;
        mem_is_load = 1; check("R9");
        cmp("R9", "jr mem load", stall, 1);
        // R10: jump-register served from MEM ALU result, then WB
        clear(); id_class = 6; id_src_a = 8; mem_dst = 8; mem_wen = 1; mem_vld = 1; check("R10");
        cmp("R10", "jr mem alu", jr_sel, 2);
        clear(); id_class = 6; id_src_a = 8; wb_dst = 8; wb_wen = 1; wb_vld = 1; check("R10");
        cmp("R10", "jr wb", jr_sel, 1);
        clear(); id_class = 1; id_src_a = 8; wb_dst = 8; wb_wen = 1; wb_vld = 1; check("R10");
        cmp("R10", "non-jr sel", jr_sel, 0);
        // Random sweep over a small register range: R1 R2 R3 R6 R7 R9
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            #1;
            ex_src_a = AW'($urandom_range(0, 3)); ex_src_b = AW'($urandom_range(0, 3));
            id_src_a = AW'($urandom_range(0, 3)); id_src_b = AW'($urandom_range(0, 3));
            id_class = 3'($urandom_range(0, 7));
            ex_dst = AW'($urandom_range(0, 3)); mem_dst = AW'($urandom_range(0, 3));
            wb_dst = AW'($urandom_range(0, 3));
            {ex_wen, ex_vld, ex_is_load} = 3'($urandom);
            {mem_wen, mem_vld, mem_is_load} = 3'($urandom);
            {wb_wen, wb_vld} = 2'($urandom);
            check("R1 R2 R3 R6 R7 R9 random");
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule